// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block is a combinational funnel shifter that works on 16-bit or 32-bit operands. A destination operand is shifted left or right by a count. The bit positions that the shift empties are filled from a second source operand. The block returns the new destination value and three flags: carry, sign and zero. Each flag has its own write-enable, so the surrounding datapath can commit only what changed. The source operand is only read and is never returned as a result. Chaining such shifts across operand-sized words gives shifts of 64 bits or more.

The count arrives as a byte, from an immediate or a count register, and only its low five bits are used. A reduced count of zero is a no-operation and all write-enables stay low. For 16-bit operands, a reduced count from 17 to 31 has no defined result. The block raises an undefined indication, passes the destination through unchanged and requests no write. The overflow flag is never written. Register access and writeback are left to the datapath around the block.

Top module: `dbl_funnel_shift`

## Requirements
- R1: With `left_i`=0 and reduced count n (1..W, where W is 32 when `wide_i`=1 and 16 when `wide_i`=0), the result is the low W bits of {src[W-1:0], dst[W-1:0]} shifted right by n. Source bit 0 arrives at result bit W-n.
- R2: With `left_i`=1 and reduced count n in 1..W, the result is the high W bits of {dst[W-1:0], src[W-1:0]} shifted left by n. Source bit W-1 arrives at result bit n-1.
- R3: The reduced count is `cnt_i` modulo 32, which is `cnt_i[4:0]`. Bits 7..5 of `cnt_i` have no effect on any output.
- R4: For a valid shift, `cf_o` is the last destination bit shifted out and `cf_we_o`=1. For a right shift this is dst[n-1]. For a left shift it is dst[W-n].
- R5: For a valid shift, `sf_o` is result bit W-1 and `zf_o` is 1 exactly when the low W bits of the result are zero. `res_we_o`, `sf_we_o` and `zf_we_o` are all 1.
- R6: A reduced count of 0 drives `res_o`=`dst_i`, drives every write-enable to 0 and keeps `undef_o`=0.
- R7: With `wide_i`=0 and a reduced count of 17 to 31, `undef_o`=1, `res_o`=`dst_i` and every write-enable is 0. In every other case `undef_o`=0.
- R8: `of_we_o` is always 0.
- R9: With `wide_i`=0 and a valid shift, `res_o[31:16]` is 0, and bits 31..16 of `dst_i` and `src_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 32 | Destination operand to be shifted |
| src_i | input | 32 | Fill operand; supplies the bits shifted in |
| cnt_i | input | 8 | Shift count (immediate or count register) |
| wide_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| left_i | input | 1 | 1 = shift left, 0 = shift right |
| res_o | output | 32 | New destination value |
| cf_o | output | 1 | Carry: last bit shifted out |
| sf_o | output | 1 | Sign of the result |
| zf_o | output | 1 | Result is zero |
| res_we_o | output | 1 | Destination write-enable |
| cf_we_o | output | 1 | Carry write-enable |
| sf_we_o | output | 1 | Sign write-enable |
| zf_we_o | output | 1 | Zero write-enable |
| of_we_o | output | 1 | Overflow write-enable (held low) |
| undef_o | output | 1 | Result undefined (16-bit, count above 16) |

## Verification
The block has no registers. The result, the flags, the write-enables and the undefined indication all settle in the same cycle that their operands are applied, with zero cycles of latency. The bench drives each vector just after a rising edge and samples every output at the following falling edge, half a period later. That edge falls inside the same cycle, so no output is read before it settles or after the next vector replaces it. Expected values come from a bit-at-a-time model in the bench that shifts one position per step. That model differs in form from the windowed shifts in the RTL.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  typedef struct packed {
    logic cf;
    logic sf;
    logic zf;
  } fsh_flags_t;
endpackage

// File: rtl/fsh_count_dec.sv
module fsh_count_dec #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wide_i,
  output logic [SH_W-1:0]  amt_o,
  output logic             zero_o,
  output logic             over_o,
  output logic             active_o
);
  localparam int HALF_W = DATA_W / 2;

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^cnt_i[CNT_W-1:SH_W];

  // modulo reduction: keep only the low SH_W bits
  assign amt_o    = cnt_i[SH_W-1:0];
  assign zero_o   = (amt_o == '0);
  assign over_o   = !wide_i && (amt_o > SH_W'(HALF_W));
  assign active_o = !zero_o && !over_o;

  always_comb begin
    p_count_excl_r3: assert (!(zero_o && over_o))
      else $error("zero and over-range both set");
    if (over_o)
      p_over_half_r7: assert (!wide_i)
        else $error("over-range flagged in wide mode");
  end
endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] lane_res [2];
  logic              lane_cy  [2];

  // lane 0 = half width, lane 1 = full width
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 1) ? DATA_W : DATA_W / 2;

    // returns {result, carry}
    function automatic logic [LW:0] fun_right(input logic [LW-1:0] d,
                                               input logic [LW-1:0] s,
                                               input logic [SH_W-1:0] n);
      logic [2*LW:0] e;
      e = {s, d, 1'b0} >> n;
      return e[LW:0];
    endfunction

    function automatic logic [LW:0] fun_left(input logic [LW-1:0] d,
                                              input logic [LW-1:0] s,
                                              input logic [SH_W-1:0] n);
      logic [2*LW:0] e;
      e = {1'b0, d, s} << n;
      return {e[2*LW-1:LW], e[2*LW]};
    endfunction

    logic [LW:0] packed_q;
    assign packed_q = left_i ? fun_left(dst_i[LW-1:0], src_i[LW-1:0], amt_i)
                             : fun_right(dst_i[LW-1:0], src_i[LW-1:0], amt_i);
    assign lane_res[g] = DATA_W'(packed_q[LW:1]);
    assign lane_cy[g]  = packed_q[0];
  end

  assign res_o   = wide_i ? lane_res[1] : lane_res[0];
  assign carry_o = wide_i ? lane_cy[1]  : lane_cy[0];

  always_comb begin
    if (!wide_i)
      p_half_upper_r9: assert (lane_res[0][DATA_W-1:DATA_W/2] == '0)
        else $error("half lane leaked into upper bits");
  end
endmodule

// File: rtl/fsh_flags.sv
module fsh_flags
  import funnel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              wide_i,
  input  logic              carry_i,
  input  logic              active_i,
  output fsh_flags_t        flags_o,
  output logic              we_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic sign_of(input logic [DATA_W-1:0] r, input logic w);
    return w ? r[DATA_W-1] : r[HALF_W-1];
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] r, input logic w);
    return w ? (r == '0) : (r[HALF_W-1:0] == '0);
  endfunction

  assign flags_o.cf = active_i & carry_i;
  assign flags_o.sf = active_i & sign_of(res_i, wide_i);
  assign flags_o.zf = active_i & is_zero(res_i, wide_i);
  assign we_o       = active_i;

  always_comb begin
    if (flags_o.zf)
      p_zero_sign_r5: assert (!flags_o.sf)
        else $error("zero and sign flags both set");
    if (!we_o)
      p_idle_flags_r6: assert (flags_o == '0)
        else $error("flag values driven without write-enable");
  end
endmodule

// File: rtl/dbl_funnel_shift.sv
module dbl_funnel_shift
  import funnel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wide_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              res_we_o,
  output logic              cf_we_o,
  output logic              sf_we_o,
  output logic              zf_we_o,
  output logic              of_we_o,
  output logic              undef_o
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  logic [SH_W-1:0]   amt;
  logic              cnt_zero, cnt_over, shift_active;
  logic [DATA_W-1:0] win_res;
  logic              win_carry;
  fsh_flags_t        flags;
  logic              flag_we;

  fsh_count_dec #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_count (
    .cnt_i   (cnt_i),
    .wide_i  (wide_i),
    .amt_o   (amt),
    .zero_o  (cnt_zero),
    .over_o  (cnt_over),
    .active_o(shift_active)
  );

  fsh_window #(.DATA_W(DATA_W), .SH_W(SH_W)) u_window (
    .dst_i  (dst_i),
    .src_i  (src_i),
    .amt_i  (amt),
    .left_i (left_i),
    .wide_i (wide_i),
    .res_o  (win_res),
    .carry_o(win_carry)
  );

  fsh_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i   (win_res),
    .wide_i  (wide_i),
    .carry_i (win_carry),
    .active_i(shift_active),
    .flags_o (flags),
    .we_o    (flag_we)
  );

  assign res_o    = shift_active ? win_res : dst_i;
  assign cf_o     = flags.cf;
  assign sf_o     = flags.sf;
  assign zf_o     = flags.zf;
  assign res_we_o = shift_active;
  assign cf_we_o  = flag_we;
  assign sf_we_o  = flag_we;
  assign zf_we_o  = flag_we;
  assign of_we_o  = 1'b0;
  assign undef_o  = cnt_over;

  always_comb begin
    p_no_overflow_r8: assert (!of_we_o)
      else $error("overflow write-enable raised");
    if (!res_we_o)
      p_passthru_r6: assert (res_o == dst_i)
        else $error("destination altered without write");
    if (undef_o)
      p_undef_nowrite_r7: assert (!res_we_o && !cf_we_o && !wide_i)
        else $error("undefined case requested a write");
    if (res_we_o && !wide_i)
      p_half_result_r9: assert (res_o[DATA_W-1:HALF_W] == '0)
        else $error("upper half set in 16-bit result");
    if (cnt_zero)
      p_zero_count_r6: assert (!res_we_o && !undef_o)
        else $error("zero count caused activity");
  end
endmodule

// File: tb/dbl_funnel_shift_tb.sv
module dbl_funnel_shift_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dst, src, res;
  logic [7:0]  cnt;
  logic        wide, left;
  logic        cf, sf, zf, res_we, cf_we, sf_we, zf_we, of_we, undef;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dbl_funnel_shift u_dut (
    .dst_i(dst), .src_i(src), .cnt_i(cnt), .wide_i(wide), .left_i(left),
    .res_o(res), .cf_o(cf), .sf_o(sf), .zf_o(zf), .res_we_o(res_we),
    .cf_we_o(cf_we), .sf_we_o(sf_we), .zf_we_o(zf_we), .of_we_o(of_we),
    .undef_o(undef)
  );

  typedef struct packed {
    logic [31:0] r;
    logic cf, sf, zf, we, undef;
  } exp_t;

  // bit-at-a-time reference
  function automatic exp_t model(input logic [31:0] d, input logic [31:0] s,
                                 input logic [7:0] c, input logic w, input logic l);
    exp_t e;
    int   wd = w ? 32 : 16;
    int   n  = c % 32;
    logic [31:0] r;
    logic cy = 1'b0;
    e = '0;
    e.r = d;
    if (n == 0) return e;
    if (!w && n > 16) begin e.undef = 1'b1; return e; end
    r = w ? d : {16'h0, d[15:0]};
    for (int k = 0; k < n; k++) begin
      if (l) begin
        cy = r[wd-1];
        r = r << 1;
        r[0] = s[wd-1-k];
      end else begin
        cy = r[0];
        r = r >> 1;
        r[wd-1] = s[k];
      end
      if (!w) r[31:16] = 16'h0;
    end
    e.r  = r;
    e.cf = cy;
    e.sf = r[wd-1];
    e.zf = (r == 32'h0);
    e.we = 1'b1;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (dst=%h src=%h cnt=%0d wide=%b left=%b)",
               tag, act, exp, dst, src, cnt, wide, left);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] s,
                       input logic [7:0] c, input logic w, input logic l);
    exp_t e;
    string rtag;
    @(posedge clk); #1;
    dst = d; src = s; cnt = c; wide = w; left = l;
    @(negedge clk);
    e = model(d, s, c, w, l);
    rtag = (c % 32 == 0) ? "R6" : e.undef ? "R7" : l ? "R2" : "R1";
    chk({rtag, " result"}, res, e.r);
    if (e.we) begin
      chk("R4 carry", {31'h0, cf}, {31'h0, e.cf});
      chk("R5 sign/zero", {30'h0, sf, zf}, {30'h0, e.sf, e.zf});
    end
    chk({rtag, " write-enables"}, {28'h0, res_we, cf_we, sf_we, zf_we}, {28'h0, {4{e.we}}});
    chk("R7 undefined", {31'h0, undef}, {31'h0, e.undef});
    chk("R8 overflow we", {31'h0, of_we}, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    dst = '0; src = '0; cnt = '0; wide = 1'b0; left = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: zero count -> passthrough, no writes (R6)
    chk("R6 idle result", res, 32'h0);
    chk("R6 idle we", {31'h0, res_we}, 32'h0);

    // directed corners
    apply(32'h8000_0001, 32'hF000_000F, 8'd1,  1'b1, 1'b0);  // R1 single
    apply(32'h8000_0001, 32'hF000_000F, 8'd1,  1'b1, 1'b1);  // R2 single
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'd31, 1'b1, 1'b0);  // R1 max
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'd31, 1'b1, 1'b1);  // R2 max
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'd32, 1'b1, 1'b1);  // R3 wraps to 0
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'hE4, 1'b1, 1'b0);  // R3 high bits ignored
    apply(32'hFFFF_ABCD, 32'hEEEE_1234, 8'd16, 1'b0, 1'b0);  // R1 half full width
    apply(32'hFFFF_ABCD, 32'hEEEE_1234, 8'd16, 1'b0, 1'b1);  // R2 half full width
    apply(32'h0000_ABCD, 32'h0000_1234, 8'd17, 1'b0, 1'b1);  // R7
    apply(32'h5555_ABCD, 32'h0000_1234, 8'd31, 1'b0, 1'b0);  // R7
    apply(32'hDEAD_0000, 32'hBEEF_0000, 8'd4,  1'b0, 1'b1);  // R9/R5 zero
    apply(32'h0000_0000, 32'h0000_0000, 8'd7,  1'b1, 1'b0);  // R5 zero wide
    apply(32'h0000_8000, 32'h0000_0000, 8'd0,  1'b0, 1'b1);  // R6

    // R9: upper bits of operands have no effect in 16-bit mode
    for (int i = 0; i < 20; i++) begin
      logic [31:0] d = $urandom, s = $urandom;
      logic [31:0] r0;
      logic [7:0]  c = 8'($urandom_range(1, 16));
      logic        l = 1'($urandom);
      apply({16'h0, d[15:0]}, {16'h0, s[15:0]}, c, 1'b0, l);
      r0 = res;
      apply(d, s, c, 1'b0, l);
      chk("R9 upper ignored", res, r0);
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c;
      logic w = 1'($urandom);
      c = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, w ? 31 : 16));
      apply($urandom, $urandom, c, w, 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule